// File: doc/BRIEF.md
# Line loss-of-signal detector

This block decides whether a received E1 line still carries a usable signal. Once per unit interval (488 ns at 2.048 Mbit/s) the receive front end presents a strobe together with one attenuation sample, expressed in dB below the nominal pulse amplitude. The block compares each sample against one of two programmable thresholds and drives a registered loss-of-signal flag that is high while loss is declared and low otherwise.

The thresholds are separate, which gives hysteresis. Loss is declared when the attenuation reaches the assert threshold, typically 20 dB. Loss is cleared only once the attenuation falls back to the clear threshold, typically 15 dB. A change of state also needs the qualifying condition to persist for a programmable number of consecutive unit intervals. This stops a short dip or a short burst of signal from toggling the flag. Each of the two delays is clamped to a floor of 10 unit intervals, so the reaction time always stays between 10 and 255 unit intervals. In a typical setup, software writes the two thresholds and the two delays once, and the flag feeds the alarm logic of the framer.

Top module: `los_detector`

## Requirements
- R1: While reset is held, and after it is released, the flag reads 1 (loss declared). The qualification count is zero, and the flag stays 1 until a signal has been qualified.
- R2: While the flag is 0, a strobed sample with `atten_db >= thr_los` is a weak sample. On the clock edge that registers the D-th consecutive weak strobe, the flag becomes 1. D is the effective declare delay.
- R3: While the flag is 1, a strobed sample with `atten_db <= thr_ok` is a good sample. On the clock edge that registers the C-th consecutive good strobe, the flag becomes 0. C is the effective clear delay.
- R4: A strobed sample that does not qualify in the current state restarts the qualification count. After such a sample, a full D or C further qualifying strobes are needed before the flag changes.
- R5: An effective delay equals the programmed 8-bit value when that value is 10 or more, and equals 10 when the value is below 10. Values 0 and 3 therefore act as 10, and 255 acts as 255.
- R6: When `ui_stb` is 0, the sample and the thresholds have no effect. The flag changes only on an edge where `ui_stb` is 1.
- R7: A sample strictly between the thresholds (`thr_ok < atten_db < thr_los`) qualifies in neither state. A run of such samples holds the current flag value indefinitely.
- R8: Equality qualifies. A sample equal to `thr_los` counts as weak, and a sample equal to `thr_ok` counts as good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ui_stb | input | 1 | One-cycle strobe per unit interval; marks a valid sample |
| atten_db | input | 8 | Attenuation sample, dB below nominal amplitude |
| thr_los | input | 8 | Attenuation at or above which a sample is weak |
| thr_ok | input | 8 | Attenuation at or below which a sample is good |
| dly_los | input | 8 | Declare delay in unit intervals, before clamping |
| dly_ok | input | 8 | Clear delay in unit intervals, before clamping |
| los | output | 1 | Loss-of-signal flag, registered, 1 while declared |

## Verification
The flag is the block's only result. It is due on the same clock edge that registers the strobe carrying the D-th or C-th qualifying sample, with no additional pipeline stage. On every other strobe, and on every cycle without a strobe, the flag must keep its previous value. The driver queues one expected flag value for each strobe it issues. The monitor compares that value with the flag 1 ns after the posedge at which the strobe is registered, so each expectation lines up with exactly one edge. Checks made during strobe-free stretches read the flag at a falling edge, well away from any update.

// File: rtl/los_pkg.sv
// Shared types for the loss-of-signal detector.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package los_pkg;

    // Line state held by the detector; the encoding is the flag value.
    typedef enum logic {
        LINK_OK   = 1'b0,
        LINK_LOST = 1'b1
    } link_state_e;

endpackage

// File: rtl/los_delay_clamp.sv
// Applies the minimum qualification window to a programmed delay.
// Assumes: MIN_Q fits in DW bits; purely combinational.
module los_delay_clamp #(
    parameter int DW    = 8,
    parameter int MIN_Q = 10
) (
    input  logic [DW-1:0] dly_raw,
    output logic [DW-1:0] dly_eff
);
    localparam logic [DW-1:0] MinVal = MIN_Q[DW-1:0];

    // Raise values under the floor to the floor.
    always_comb begin
        dly_eff = (dly_raw < MinVal) ? MinVal : dly_raw;
    end
endmodule

// File: rtl/los_sample_qual.sv
// Decides whether one attenuation sample supports leaving the current state.
// Assumes: thresholds are stable while a strobe is presented.
module los_sample_qual #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] atten_db,
    input  logic [AW-1:0] thr_los,
    input  logic [AW-1:0] thr_ok,
    input  logic          lost,
    output logic          qual
);
    // Weak test while the line is up, good test while it is down.
    always_comb begin
        if (lost) qual = (atten_db <= thr_ok);
        else      qual = (atten_db >= thr_los);
    end
endmodule

// File: rtl/los_qual_cnt.sv
// Counts consecutive qualifying strobes and flags when the window is met.
// Assumes: limit >= 1; a non-qualifying strobe or an expiry restarts the count.
module los_qual_cnt #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          qual,
    input  logic [DW-1:0] limit,
    output logic          expire
);
    logic [DW-1:0] cnt_q;
    logic [DW:0]   cnt_inc;

    // Count that this strobe would reach, one bit wider than the counter.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{DW{1'b0}}, 1'b1};
        expire  = stb && qual && (cnt_inc >= {1'b0, limit});
    end

    // Advance on a qualifying strobe, restart on a break or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (stb) begin
            if (!qual || expire) cnt_q <= '0;
            else                 cnt_q <= cnt_inc[DW-1:0];
        end
    end

    // R4
    break_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb && !qual |=> cnt_q == '0);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(cnt_q));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> cnt_q == '0);
endmodule

// File: rtl/los_detector.sv
// Loss-of-signal detector with hysteresis and per-UI qualification delays.
// Assumes: one ui_stb pulse per unit interval; synchronous active-low reset;
// the flag powers up declared and clears only after a qualified signal.
module los_detector
    import los_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int MIN_Q = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ui_stb,
    input  logic [AW-1:0] atten_db,
    input  logic [AW-1:0] thr_los,
    input  logic [AW-1:0] thr_ok,
    input  logic [DW-1:0] dly_los,
    input  logic [DW-1:0] dly_ok,
    output logic          los
);
    localparam int NDLY = 2;   // index 0: declare, index 1: clear

    link_state_e   state_q;
    logic          lost;
    logic          qual;
    logic          expire;
    logic [DW-1:0] limit;
    logic [DW-1:0] dly_raw [NDLY];
    logic [DW-1:0] dly_eff [NDLY];

    assign dly_raw[0] = dly_los;
    assign dly_raw[1] = dly_ok;

    // One clamp per programmed delay.
    for (genvar g = 0; g < NDLY; g++) begin : g_clamp
        los_delay_clamp #(.DW(DW), .MIN_Q(MIN_Q)) u_clamp (
            .dly_raw (dly_raw[g]),
            .dly_eff (dly_eff[g])
        );
    end

    assign lost = (state_q == LINK_LOST);

    // Window that applies to the transition out of the current state.
    always_comb begin
        limit = lost ? dly_eff[1] : dly_eff[0];
    end

    los_sample_qual #(.AW(AW)) u_qual (
        .atten_db (atten_db),
        .thr_los  (thr_los),
        .thr_ok   (thr_ok),
        .lost     (lost),
        .qual     (qual)
    );

    los_qual_cnt #(.DW(DW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (ui_stb),
        .qual   (qual),
        .limit  (limit),
        .expire (expire)
    );

    // Flip the line state when the qualification window completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= LINK_LOST;
        else if (expire) state_q <= lost ? LINK_OK : LINK_LOST;
    end

    assign los = lost;

    // R1
    reset_declared_chk: assert property (@(posedge clk)
        !rst_n |=> los);

    // R6
    strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(los) |-> $past(ui_stb));

    // R2
    declare_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> $past(atten_db >= thr_los));

    // R3
    clear_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> $past(atten_db <= thr_ok));
endmodule

// File: tb/los_detector_test.sv
`timescale 1ns/1ps
module los_detector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ui_stb = 1'b0;
    logic [7:0] atten_db = 8'd0;
    logic [7:0] thr_los = 8'd20;
    logic [7:0] thr_ok = 8'd15;
    logic [7:0] dly_los = 8'd12;
    logic [7:0] dly_ok = 8'd12;
    logic       los;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    los_detector uut (
        .clk(clk), .rst_n(rst_n), .ui_stb(ui_stb), .atten_db(atten_db),
        .thr_los(thr_los), .thr_ok(thr_ok), .dly_los(dly_los),
        .dly_ok(dly_ok), .los(los)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: los=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one strobe per call, expected flag pushed to the scoreboard.
    task automatic drive(input logic [7:0] a, input bit exp, input string tag);
        @(negedge clk);
        atten_db = a;
        ui_stb   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        ui_stb = 1'b0;
    endtask

    task automatic drive_n(input logic [7:0] a, input int n, input bit exp,
                           input string tag);
        for (int i = 0; i < n; i++) drive(a, exp, tag);
    endtask

    // Monitor: the flag is due at the edge that registers the strobe.
    always @(posedge clk) begin
        if (rst_n && ui_stb) begin
            #1;
            if (exp_q.size() == 0) begin
                check(1'b1, 1'b0, "scoreboard underflow");
            end else begin
                check(los, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(los, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(los, 1'b1, "R1 after reset");

        // R3: twelve good samples clear the flag on the twelfth
        drive_n(8'd5, 11, 1'b1, "R3 clear window");
        drive(8'd5, 1'b0, "R3 clear edge");

        // R6: strong loss samples without strobe are ignored
        atten_db = 8'd40;
        repeat (300) @(negedge clk);
        check(los, 1'b0, "R6 no strobe");

        // R2 / R8: sample equal to the declare threshold is weak
        drive_n(8'd20, 11, 1'b0, "R2 R8 declare window");
        drive(8'd20, 1'b1, "R2 R8 declare edge");

        // R4 / R8: a break restarts the clear count; equality is good
        drive_n(8'd15, 5, 1'b1, "R4 pre-break");
        drive(8'd30, 1'b1, "R4 break");
        drive_n(8'd15, 11, 1'b1, "R4 R8 restarted window");
        drive(8'd15, 1'b0, "R4 R8 clear edge");

        // R7: samples between thresholds hold the clear state
        drive_n(8'd17, 300, 1'b0, "R7 hold ok");
        drive_n(8'd25, 6, 1'b0, "R4 weak run");
        drive(8'd17, 1'b0, "R4 R7 mid break");
        drive_n(8'd25, 11, 1'b0, "R4 restarted declare");
        drive(8'd25, 1'b1, "R2 declare edge");
        drive_n(8'd17, 300, 1'b1, "R7 hold lost");
        drive_n(8'd16, 20, 1'b1, "R8 just above clear");

        // R5: small delays are clamped to ten, large ones used as given
        @(negedge clk); dly_ok = 8'd3;
        drive_n(8'd0, 9, 1'b1, "R5 clear min window");
        drive(8'd0, 1'b0, "R5 clear min edge");
        @(negedge clk); dly_los = 8'd0;
        drive_n(8'd200, 9, 1'b0, "R5 declare min window");
        drive(8'd200, 1'b1, "R5 declare min edge");
        @(negedge clk); dly_ok = 8'd255;
        drive_n(8'd10, 254, 1'b1, "R5 clear max window");
        drive(8'd10, 1'b0, "R5 clear max edge");
        @(negedge clk); dly_los = 8'd10;
        drive_n(8'd21, 9, 1'b0, "R5 declare ten window");
        drive(8'd21, 1'b1, "R5 declare ten edge");

        // R1: reset re-declares loss
        drive_n(8'd1, 4, 1'b1, "R1 partial clear");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(los, 1'b1, "R1 re-reset");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, 1'b1, "scoreboard drained");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: expired, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule